// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

A purely combinational arithmetic and logic unit for a small accumulator machine. It takes an operation code, a width select, two operands (the accumulator value A and the memory operand M) and the four incoming condition flags: negative N, zero Z, overflow V and carry C. In the same cycle it returns a result, a strobe that says whether the result is to be written back to the accumulator, and the four next flag values. Each operation class has its own flag rule, and the unit applies that rule.

Operands are 8 bits wide in narrow mode. In wide mode they are 16 bits, for the double-accumulator path. The surrounding datapath owns the registers, instruction decode and memory access. It feeds this unit and latches `res_o` when `wr_o` is high, and it latches the flag outputs.

Top module: `accalu_top`

## Requirements
- R1: Op code 0 is add and op code 1 is add-with-carry (the incoming C becomes the carry-in at bit 0). Both write the result A+M(+C) modulo 2^w. C_out is 1 when the unsigned sum exceeds 2^w−1. V_out is 1 when the signed sum falls outside the signed w-bit range.
- R2: Op code 2 is subtract and op code 3 is subtract-with-borrow (the incoming C is subtracted at bit 0). Op code 13 is compare. All three compute A−M(−C). C_out is 1 when the true difference is negative, and V_out is 1 when the signed difference is outside the signed range. Subtract and subtract-with-borrow write the difference. Compare leaves wr_o low.
- R3: For every op code from 0 to 14, N_out is the top result bit (bit 7 when wide_i=0, bit 15 when wide_i=1), and Z_out is 1 exactly when the w-bit value is zero.
- R4: With wide_i=0, bits 15:8 of a_i and m_i have no effect, bits 15:8 of res_o are 0, and w=8. With wide_i=1, w=16.
- R5: Op codes 5 (AND), 6 (OR) and 7 (XOR) write the bitwise A op M, force V_out to 0 and pass C through unchanged.
- R6: Op code 8 (complement) writes the bitwise inverse of A, forces V_out to 0 and forces C_out to 1.
- R7: Op code 9 (clear) writes zero and forces N,Z,V,C to 0,1,0,0.
- R8: Op code 12 (test) derives N and Z from A, forces V_out and C_out to 0, and leaves wr_o low.
- R9: Op code 14 (bit test) derives N and Z from A AND M, forces V_out to 0, passes C through, and leaves wr_o low.
- R10: Op code 10 (increment) writes A+1 and op code 11 (decrement) writes A−1. Both set V_out only on the step from the largest positive value to the most negative value, or the reverse, and both pass C through.
- R11: Op code 4 (negate) writes 0−A. V_out is 1 only when A is the most negative value, and C_out is 1 whenever A is nonzero.
- R12: When wr_o is low, res_o is 0. Op code 15 is reserved: it leaves wr_o low and passes all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| wide_i | input | 1 | 0 = 8-bit operation, 1 = 16-bit operation |
| a_i | input | 16 | Accumulator operand |
| m_i | input | 16 | Memory operand |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| v_i | input | 1 | Incoming overflow flag |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result value |
| wr_o | output | 1 | Result is to be written to the accumulator |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| v_o | output | 1 | Next overflow flag |
| c_o | output | 1 | Next carry flag |

## Verification
The unit holds no state, so any internal fault shows on the outputs in the same evaluation as the offending input, with no delay. A wrong operand set-up, such as a missing inversion or a wrong carry-in, appears at once as a wrong sum or a wrong C/V pair. Boundary vectors expose it: 0x7F/0x80, 0xFF+1, 0−0 and the 16-bit equivalents. A wrong lane or width select appears as N taken from the wrong bit, or as upper result bits leaking into narrow mode. Each flag rule is checked against values that the bench computes with integer arithmetic.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  localparam int unsigned NARROW_W = 8;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_NEG  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_COM  = 4'd8,
    OP_CLR  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_TST  = 4'd12,
    OP_CMP  = 4'd13,
    OP_BIT  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  end

  assign sum_o  = wide_sum[W-1:0];
  assign cout_o = wide_sum[W];
  // same-sign operands whose sum changes sign
  assign ovf_o  = (x_i[W-1] == y_i[W-1]) && (wide_sum[W-1] != x_i[W-1]);
endmodule

// File: rtl/accalu_logic.sv
module accalu_logic #(
  parameter int unsigned W = 16
) (
  input  accalu_pkg::alu_op_e op_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        m_i,
  output logic [W-1:0]        out_o
);
  import accalu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_BIT: out_o = a_i & m_i;
      OP_OR:          out_o = a_i | m_i;
      OP_XOR:         out_o = a_i ^ m_i;
      OP_COM:         out_o = ~a_i;
      default:        out_o = '0;
    endcase
  end
endmodule

// File: rtl/accalu_nz.sv
module accalu_nz #(
  parameter int unsigned NW = 8,
  localparam int unsigned WW = 2 * NW
) (
  input  logic [WW-1:0] val_i,
  input  logic          wide_i,
  output logic          n_o,
  output logic          z_o
);
  always_comb begin
    if (wide_i) begin
      n_o = val_i[WW-1];
      z_o = (val_i == '0);
    end else begin
      n_o = val_i[NW-1];
      z_o = (val_i[NW-1:0] == '0);
    end
  end
endmodule

// File: rtl/accalu_top.sv
module accalu_top #(
  parameter int unsigned NW = accalu_pkg::NARROW_W,
  localparam int unsigned WW = 2 * NW
) (
  input  logic [3:0]    op_i,
  input  logic          wide_i,
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] m_i,
  input  logic          n_i,
  input  logic          z_i,
  input  logic          v_i,
  input  logic          c_i,
  output logic [WW-1:0] res_o,
  output logic          wr_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o
);
  import accalu_pkg::*;

  localparam int unsigned LANES = 2;

  alu_op_e       op;
  logic [WW-1:0] width_mask;
  logic [WW-1:0] a_m;
  logic [WW-1:0] m_m;
  logic [WW-1:0] add_x;
  logic [WW-1:0] add_y;
  logic          add_cin;
  logic          is_sub;
  logic [WW-1:0] lane_sum [LANES];
  logic          lane_co  [LANES];
  logic          lane_ov  [LANES];
  logic [WW-1:0] ar_sum;
  logic          ar_co;
  logic          ar_ov;
  logic [WW-1:0] lg_raw;
  logic [WW-1:0] lg_out;
  logic [WW-1:0] flag_val;
  logic          nz_n;
  logic          nz_z;
  logic          use_nz;
  logic          wr;
  ccr_t          ccr_in;
  ccr_t          ccr_nx;

  assign op         = alu_op_e'(op_i);
  assign width_mask = wide_i ? {WW{1'b1}} : {{NW{1'b0}}, {NW{1'b1}}};
  assign a_m        = a_i & width_mask;
  assign m_m        = m_i & width_mask;
  assign ccr_in     = '{n: n_i, z: z_i, v: v_i, c: c_i};

  // adder operand set-up: subtraction becomes x + ~y + 1
  always_comb begin
    add_x   = a_m;
    add_y   = m_m;
    add_cin = 1'b0;
    is_sub  = 1'b0;
    unique case (op)
      OP_ADC: add_cin = c_i;
      OP_SUB, OP_CMP: begin
        add_y   = ~m_m;
        add_cin = 1'b1;
        is_sub  = 1'b1;
      end
      OP_SBC: begin
        add_y   = ~m_m;
        add_cin = ~c_i;
        is_sub  = 1'b1;
      end
      OP_NEG: begin
        add_x   = '0;
        add_y   = ~a_m;
        add_cin = 1'b1;
        is_sub  = 1'b1;
      end
      OP_INC: begin
        add_y   = '0;
        add_cin = 1'b1;
      end
      OP_DEC: begin
        add_y   = {WW{1'b1}};
        add_cin = 1'b0;
      end
      default: ;
    endcase
  end

  // one adder lane per operand width: lane 0 narrow, lane 1 wide
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LW = NW * (g + 1);
    logic [LW-1:0] s_l;

    accalu_addsub #(.W(LW)) u_add (
      .x_i    (add_x[LW-1:0]),
      .y_i    (add_y[LW-1:0]),
      .cin_i  (add_cin),
      .sum_o  (s_l),
      .cout_o (lane_co[g]),
      .ovf_o  (lane_ov[g])
    );

    assign lane_sum[g] = WW'(s_l);
  end

  assign ar_sum = wide_i ? lane_sum[1] : lane_sum[0];
  assign ar_co  = wide_i ? lane_co[1]  : lane_co[0];
  assign ar_ov  = wide_i ? lane_ov[1]  : lane_ov[0];

  accalu_logic #(.W(WW)) u_logic (
    .op_i  (op),
    .a_i   (a_m),
    .m_i   (m_m),
    .out_o (lg_raw)
  );

  assign lg_out = lg_raw & width_mask;

  accalu_nz #(.NW(NW)) u_nz (
    .val_i  (flag_val),
    .wide_i (wide_i),
    .n_o    (nz_n),
    .z_o    (nz_z)
  );

  // per-class flag rules
  always_comb begin
    flag_val = '0;
    wr       = 1'b0;
    use_nz   = 1'b1;
    ccr_nx   = ccr_in;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
        flag_val = ar_sum;
        wr       = (op != OP_CMP);
        ccr_nx.v = ar_ov;
        ccr_nx.c = is_sub ? ~ar_co : ar_co;
      end
      OP_INC, OP_DEC: begin
        flag_val = ar_sum;
        wr       = 1'b1;
        ccr_nx.v = ar_ov;
      end
      OP_AND, OP_OR, OP_XOR, OP_BIT: begin
        flag_val = lg_out;
        wr       = (op != OP_BIT);
        ccr_nx.v = 1'b0;
      end
      OP_COM: begin
        flag_val = lg_out;
        wr       = 1'b1;
        ccr_nx.v = 1'b0;
        ccr_nx.c = 1'b1;
      end
      OP_CLR: begin
        flag_val = '0;
        wr       = 1'b1;
        ccr_nx.v = 1'b0;
        ccr_nx.c = 1'b0;
      end
      OP_TST: begin
        flag_val = a_m;
        ccr_nx.v = 1'b0;
        ccr_nx.c = 1'b0;
      end
      default: use_nz = 1'b0;
    endcase
    if (use_nz) begin
      ccr_nx.n = nz_n;
      ccr_nx.z = nz_z;
    end
  end

  assign res_o = wr ? flag_val : '0;
  assign wr_o  = wr;
  assign n_o   = ccr_nx.n;
  assign z_o   = ccr_nx.z;
  assign v_o   = ccr_nx.v;
  assign c_o   = ccr_nx.c;
endmodule

// File: rtl/accalu_chk.sv
module accalu_chk #(
  parameter int unsigned NW = 8,
  localparam int unsigned WW = 2 * NW
) (
  input logic [3:0]    op_i,
  input logic          wide_i,
  input logic [WW-1:0] a_i,
  input logic [WW-1:0] m_i,
  input logic          n_i,
  input logic          z_i,
  input logic          v_i,
  input logic          c_i,
  input logic [WW-1:0] res_o,
  input logic          wr_o,
  input logic          n_o,
  input logic          z_o,
  input logic          v_o,
  input logic          c_o
);
  logic [WW-1:0] msk;
  assign msk = wide_i ? {WW{1'b1}} : {{NW{1'b0}}, {NW{1'b1}}};

  always_comb begin
    AST_NARROW_UPPER_ZERO: assert (wide_i || res_o[WW-1:NW] == '0) else $error("narrow upper bits"); // R4
    AST_ZERO_FLAG: assert (!wr_o || z_o == ((res_o & msk) == '0)) else $error("zero flag"); // R3
    AST_NO_WRITE_RES: assert (wr_o || res_o == '0) else $error("result without write"); // R12
    AST_CMP_NO_WRITE: assert (op_i != 4'd13 || !wr_o) else $error("compare wrote"); // R2
    AST_LOGIC_FLAGS: assert (!(op_i inside {4'd5, 4'd6, 4'd7}) || (!v_o && c_o == c_i && wr_o)) else $error("logic flags"); // R5
    AST_COM_FLAGS: assert (op_i != 4'd8 || (c_o && !v_o && res_o == (~a_i & msk))) else $error("complement"); // R6
    AST_CLR_FLAGS: assert (op_i != 4'd9 || ({n_o, z_o, v_o, c_o} == 4'b0100 && res_o == '0 && wr_o)) else $error("clear"); // R7
    AST_TST_FLAGS: assert (op_i != 4'd12 || (!v_o && !c_o && !wr_o)) else $error("test"); // R8
    AST_BIT_FLAGS: assert (op_i != 4'd14 || (!v_o && c_o == c_i && !wr_o)) else $error("bit test"); // R9
    AST_INCDEC_KEEP_C: assert (!(op_i inside {4'd10, 4'd11}) || c_o == c_i) else $error("inc/dec carry"); // R10
    AST_NEG_CARRY: assert (op_i != 4'd4 || c_o == ((a_i & msk) != '0)) else $error("negate carry"); // R11
    AST_RSVD_PASS: assert (op_i != 4'd15 || ({n_o, z_o, v_o, c_o} == {n_i, z_i, v_i, c_i} && !wr_o)) else $error("reserved"); // R12
  end
endmodule

bind accalu_top accalu_chk #(.NW(NW)) u_chk (.*);

// File: tb/accalu_top_test.sv
module accalu_top_test;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic        wide;
  logic [15:0] a;
  logic [15:0] m;
  logic [3:0]  fin;
  logic [15:0] res;
  logic        wr;
  logic        n_o, z_o, v_o, c_o;
  int          checks;
  int          errors;
  bit          done;

  accalu_top uut (
    .op_i(op), .wide_i(wide), .a_i(a), .m_i(m),
    .n_i(fin[3]), .z_i(fin[2]), .v_i(fin[1]), .c_i(fin[0]),
    .res_o(res), .wr_o(wr), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sx(input int x, input int half);
    return (x >= half) ? x - 2 * half : x;
  endfunction

  function automatic bit out_of_range(input int s, input int half);
    return (s > half - 1) || (s < -half);
  endfunction

  // integer reference model built from the requirements
  function automatic void model(input logic [3:0] o, input logic w16,
                                input logic [15:0] av_l, input logic [15:0] mv_l,
                                input logic [3:0] f, output logic [15:0] r,
                                output logic w, output logic [3:0] fo);
    int mask, half, av, mv, ci, u, s, val;
    logic n, z, v, c;
    bit use_nz;
    mask = w16 ? 65535 : 255;
    half = w16 ? 32768 : 128;
    av = int'(av_l) & mask;
    mv = int'(mv_l) & mask;
    ci = int'(f[0]);
    {n, z, v, c} = f;
    use_nz = 1'b1;
    w = 1'b0;
    val = 0;
    case (o)
      4'd0, 4'd1: begin
        u = av + mv + ((o == 4'd1) ? ci : 0);
        s = sx(av, half) + sx(mv, half) + ((o == 4'd1) ? ci : 0);
        val = u & mask; c = (u > mask); v = out_of_range(s, half); w = 1'b1;
      end
      4'd2, 4'd3, 4'd13: begin
        u = av - mv - ((o == 4'd3) ? ci : 0);
        s = sx(av, half) - sx(mv, half) - ((o == 4'd3) ? ci : 0);
        val = u & mask; c = (u < 0); v = out_of_range(s, half); w = (o != 4'd13);
      end
      4'd4: begin
        u = -av; s = -sx(av, half);
        val = u & mask; c = (u < 0); v = out_of_range(s, half); w = 1'b1;
      end
      4'd5: begin val = av & mv; v = 1'b0; w = 1'b1; end
      4'd6: begin val = av | mv; v = 1'b0; w = 1'b1; end
      4'd7: begin val = av ^ mv; v = 1'b0; w = 1'b1; end
      4'd8: begin val = (~av) & mask; v = 1'b0; c = 1'b1; w = 1'b1; end
      4'd9: begin val = 0; v = 1'b0; c = 1'b0; w = 1'b1; end
      4'd10: begin val = (av + 1) & mask; v = out_of_range(sx(av, half) + 1, half); w = 1'b1; end
      4'd11: begin val = (av - 1) & mask; v = out_of_range(sx(av, half) - 1, half); w = 1'b1; end
      4'd12: begin val = av; v = 1'b0; c = 1'b0; end
      4'd14: begin val = av & mv; v = 1'b0; end
      default: use_nz = 1'b0;
    endcase
    if (use_nz) begin
      n = ((val & half) != 0);
      z = (val == 0);
    end
    r = w ? val[15:0] : 16'h0;
    fo = {n, z, v, c};
  endfunction

  task automatic apply(input string req, input logic [3:0] o, input logic w16,
                       input logic [15:0] av, input logic [15:0] mv, input logic [3:0] f);
    logic [15:0] er;
    logic        ew;
    logic [3:0]  ef;
    @(negedge clk);
    op = o; wide = w16; a = av; m = mv; fin = f;
    model(o, w16, av, mv, f, er, ew, ef);
    #2;
    checks++;
    if (res !== er || wr !== ew || {n_o, z_o, v_o, c_o} !== ef) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0b a=%h m=%h f=%b: actual res=%h wr=%b nzvc=%b expected res=%h wr=%b nzvc=%b",
               req, o, w16, av, mv, f, res, wr, {n_o, z_o, v_o, c_o}, er, ew, ef);
    end
  endtask

  task automatic t_reserved();  // R12
    apply("R12", 4'd15, 1'b0, 16'h1234, 16'h00FF, 4'b0000);
    apply("R12", 4'd15, 1'b1, 16'h8000, 16'hFFFF, 4'b1111);
    apply("R12", 4'd15, 1'b0, 16'h0000, 16'h0000, 4'b1010);
  endtask

  task automatic t_add();  // R1
    apply("R1", 4'd0, 1'b0, 16'h007F, 16'h0001, 4'b0000);
    apply("R1", 4'd0, 1'b0, 16'h00FF, 16'h0001, 4'b0000);
    apply("R1", 4'd0, 1'b0, 16'h0080, 16'h0080, 4'b0000);
    apply("R1", 4'd1, 1'b0, 16'h00FE, 16'h0001, 4'b0001);
    apply("R1", 4'd1, 1'b0, 16'h0010, 16'h0020, 4'b0000);
    apply("R1", 4'd1, 1'b1, 16'hFFFF, 16'h0000, 4'b0001);
    apply("R1", 4'd0, 1'b1, 16'h7FFF, 16'h0001, 4'b0000);
  endtask

  task automatic t_sub();  // R2
    apply("R2", 4'd2, 1'b0, 16'h0000, 16'h0001, 4'b0000);
    apply("R2", 4'd2, 1'b0, 16'h0080, 16'h0001, 4'b0000);
    apply("R2", 4'd3, 1'b0, 16'h0005, 16'h0005, 4'b0001);
    apply("R2", 4'd3, 1'b0, 16'h0005, 16'h0004, 4'b0001);
    apply("R2", 4'd13, 1'b0, 16'h0042, 16'h0042, 4'b0001);
    apply("R2", 4'd13, 1'b1, 16'h1000, 16'h2000, 4'b0000);
    apply("R2", 4'd2, 1'b1, 16'h8000, 16'h0001, 4'b0000);
  endtask

  task automatic t_nz();  // R3
    apply("R3", 4'd5, 1'b1, 16'h8001, 16'h8000, 4'b0000);
    apply("R3", 4'd5, 1'b1, 16'h0080, 16'h00FF, 4'b0000);
    apply("R3", 4'd6, 1'b1, 16'h0000, 16'h0000, 4'b0000);
    apply("R3", 4'd6, 1'b0, 16'h0000, 16'h0000, 4'b1001);
  endtask

  task automatic t_narrow();  // R4
    apply("R4", 4'd0, 1'b0, 16'hAB10, 16'hCD20, 4'b0000);
    apply("R4", 4'd7, 1'b0, 16'hFF00, 16'h0F00, 4'b0000);
    apply("R4", 4'd12, 1'b0, 16'h8000, 16'h0000, 4'b0000);
    apply("R4", 4'd11, 1'b0, 16'h1200, 16'h0000, 4'b0000);
  endtask

  task automatic t_logic();  // R5
    apply("R5", 4'd5, 1'b0, 16'h00F0, 16'h003C, 4'b0011);
    apply("R5", 4'd6, 1'b0, 16'h0080, 16'h0001, 4'b0010);
    apply("R5", 4'd7, 1'b0, 16'h00AA, 16'h00AA, 4'b0011);
  endtask

  task automatic t_com();  // R6
    apply("R6", 4'd8, 1'b0, 16'h00FF, 16'h0000, 4'b0010);
    apply("R6", 4'd8, 1'b1, 16'h0F0F, 16'h0000, 4'b0000);
  endtask

  task automatic t_clr();  // R7
    apply("R7", 4'd9, 1'b0, 16'h00FF, 16'h00FF, 4'b1011);
    apply("R7", 4'd9, 1'b1, 16'h8000, 16'h1234, 4'b1111);
  endtask

  task automatic t_tst();  // R8
    apply("R8", 4'd12, 1'b0, 16'h0080, 16'h0000, 4'b0011);
    apply("R8", 4'd12, 1'b1, 16'h0000, 16'hFFFF, 4'b0011);
  endtask

  task automatic t_bit();  // R9
    apply("R9", 4'd14, 1'b0, 16'h00F0, 16'h000F, 4'b0011);
    apply("R9", 4'd14, 1'b0, 16'h00F0, 16'h0080, 4'b0000);
  endtask

  task automatic t_incdec();  // R10
    apply("R10", 4'd10, 1'b0, 16'h007F, 16'h0000, 4'b0001);
    apply("R10", 4'd10, 1'b0, 16'h00FF, 16'h0000, 4'b0000);
    apply("R10", 4'd11, 1'b0, 16'h0080, 16'h0000, 4'b0000);
    apply("R10", 4'd11, 1'b0, 16'h0000, 16'h0000, 4'b0001);
    apply("R10", 4'd10, 1'b1, 16'h7FFF, 16'h0000, 4'b0000);
  endtask

  task automatic t_neg();  // R11
    apply("R11", 4'd4, 1'b0, 16'h0000, 16'h0000, 4'b0001);
    apply("R11", 4'd4, 1'b0, 16'h0080, 16'h0000, 4'b0000);
    apply("R11", 4'd4, 1'b0, 16'h0001, 16'h0000, 4'b0000);
    apply("R11", 4'd4, 1'b1, 16'h8000, 16'h0000, 4'b0000);
  endtask

  task automatic t_sweep();  // R1 R2 R3 R12 over mixed patterns
    logic [31:0] st;
    st = 32'h1F2E3D4C;
    for (int i = 0; i < 3000; i++) begin
      st = st ^ (st << 13);
      st = st ^ (st >> 17);
      st = st ^ (st << 5);
      apply("R3", st[3:0], st[4], st[20:5], {st[31:21], st[8:4]}, st[12:9]);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    op = 4'd15; wide = 1'b0; a = '0; m = '0; fin = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: reserved code with cleared flags yields zero outputs
    @(negedge clk); #2;
    checks++;
    if (res !== 16'h0 || wr !== 1'b0 || {n_o, z_o, v_o, c_o} !== 4'b0000) begin
      errors++;
      $display("FAIL R12 idle: actual res=%h wr=%b nzvc=%b expected res=0000 wr=0 nzvc=0000",
               res, wr, {n_o, z_o, v_o, c_o});
    end
    t_reserved();
    t_add();
    t_sub();
    t_nz();
    t_narrow();
    t_logic();
    t_com();
    t_clr();
    t_tst();
    t_bit();
    t_incdec();
    t_neg();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule